// File: doc/BRIEF.md
# NAND Mode-Register Bus Bridge

This block lets a 16-bit host register bus operate an 8-bit raw NAND flash device. The host sees three registers: data at address 0, mode at address 1 and status at address 2. A single mode byte sets every NAND control pin at once: chip enable, command latch, address latch, write protect, card power and an activity indicator. A data access then runs one or two flash strobe cycles. A 16-bit access is split into two byte cycles on the flash side, and a byte access makes exactly one cycle. This is how a lone opcode such as the reset command 0xFF is issued in command mode.

Each flash cycle holds its strobe low for `PHASE_CLKS` clocks and then high for the same number of clocks. Write data stays on the flash bus through the whole cycle. A host access is held off until its flash cycles are complete, and is then answered with a one-clock acknowledge. The ready/busy line of the flash is registered and can be read in the status register.

Top module: `nand_mode_bridge`

## Requirements
- R1: After reset, the flash outputs are idle: `nf_ce_n`, `nf_we_n` and `nf_re_n` are 1; `nf_cle`, `nf_ale`, `nf_wp_n`, `card_pwr`, `act_led` and `hst_ack` are 0; the mode register reads 0x00.
- R2: The mode bits map to pins as follows: bit0 drives `nf_cle`, bit1 drives `nf_ale`, bit2 drives `card_pwr`, bit3 drives `act_led`, bit4 drives chip enable (`nf_ce_n` = !bit4) and bit7 drives `nf_wp_n`. Bits 5 and 6 drive no pin. All eight bits read back at address 1 in `hst_rdata[7:0]`, and the upper byte reads 0.
- R3: Mode 0x94 selects data transfer (CE active, CLE=0, ALE=0). Mode 0x95 selects command (CLE=1). Mode 0x96 selects address (ALE=1). Mode 0x00 is standby with CE released. Mode 0x0C turns card power on and 0x08 turns it off.
- R4: A 16-bit data write (`hst_wide`=1) makes two flash write cycles, first `hst_wdata[7:0]` and then `hst_wdata[15:8]`. In each cycle `nf_we_n` is low for exactly `PHASE_CLKS` clocks.
- R5: An 8-bit data write (`hst_wide`=0) makes exactly one write cycle carrying `hst_wdata[7:0]`. In command mode this is one command latch cycle.
- R6: During a write cycle `nf_dq_oe` is 1, and `nf_dq_o` holds the same value from the falling edge of `nf_we_n` until after its rising edge.
- R7: A 16-bit data read makes two `nf_re_n` cycles of `PHASE_CLKS` low clocks each. The first byte read goes to `hst_rdata[7:0]` and the second to `hst_rdata[15:8]`. An 8-bit read makes one cycle and returns 0 in the upper byte. The byte is sampled in the last low clock.
- R8: `hst_ack` is a one-clock pulse. It comes 1 clock after a mode or status request, 2*`PHASE_CLKS`+1 clocks after a byte data request, and 4*`PHASE_CLKS`+1 clocks after a 16-bit data request.
- R9: Status bit 7 reads 1 while `nf_rb_n` is low (busy), with one clock of registering delay. All other status bits read 0.
- R10: The mode register changes only between data accesses. The control pins are stable through every flash cycle, and a new mode applies to the next data cycle.
- R11: `nf_we_n` and `nf_re_n` are never low in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hst_req | input | 1 | Host request, held until acknowledge |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_wide | input | 1 | Data access width: 1 = 16 bit, 0 = 8 bit |
| hst_addr | input | 2 | 0 data, 1 mode, 2 status |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, valid with acknowledge |
| hst_ack | output | 1 | One-clock completion pulse |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_wp_n | output | 1 | Write protect release |
| nf_dq_o | output | 8 | Flash data out |
| nf_dq_oe | output | 1 | Flash data output enable |
| nf_dq_i | input | 8 | Flash data in |
| nf_rb_n | input | 1 | Flash ready/busy, low = busy |
| card_pwr | output | 1 | Card power supply enable |
| act_led | output | 1 | Activity indicator |

## Verification
The control pins are decoded from the stored mode byte, so a corrupted mode register shows up at once as a wrong CLE, ALE or CE level. It also shows on the next read of address 1. A wrong phase counter or byte index changes the strobe low length, the number of strobes or the byte order, and any of these is visible within the first flash cycle of an access. A mistake in the completion logic moves the acknowledge away from its fixed latency for that access kind.

// File: rtl/nand_mode_bridge.sv
module nand_mode_bridge #(
  parameter int PHASE_CLKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hst_req,
  input  logic        hst_wr,
  input  logic        hst_wide,
  input  logic [1:0]  hst_addr,
  input  logic [15:0] hst_wdata,
  output logic [15:0] hst_rdata,
  output logic        hst_ack,
  output logic        nf_ce_n,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_we_n,
  output logic        nf_re_n,
  output logic        nf_wp_n,
  output logic [7:0]  nf_dq_o,
  output logic        nf_dq_oe,
  input  logic [7:0]  nf_dq_i,
  input  logic        nf_rb_n,
  output logic        card_pwr,
  output logic        act_led
);

  localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CLKS - 1);
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic        idx, wide_q, rd_q, rb_q;
  logic [7:0]  mode_q;
  logic [15:0] wbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      idx       <= 1'b0;
      wide_q    <= 1'b0;
      rd_q      <= 1'b0;
      rb_q      <= 1'b1;
      mode_q    <= 8'h00;
      wbuf      <= '0;
      hst_rdata <= '0;
      hst_ack   <= 1'b0;
    end else begin
      rb_q    <= nf_rb_n;
      hst_ack <= 1'b0;
      case (st)
        S_IDLE: if (hst_req && !hst_ack) begin
          if (hst_addr == A_DATA) begin
            st        <= S_LOW;
            cnt       <= '0;
            idx       <= 1'b0;
            wide_q    <= hst_wide;
            rd_q      <= !hst_wr;
            wbuf      <= hst_wdata;
            hst_rdata <= '0;
          end else begin
            if (hst_wr && hst_addr == A_MODE) mode_q <= hst_wdata[7:0];
            case (hst_addr)
              A_MODE:  hst_rdata <= {8'h00, mode_q};
              A_STAT:  hst_rdata <= {8'h00, !rb_q, 7'h00};
              default: hst_rdata <= '0;
            endcase
            hst_ack <= 1'b1;
          end
        end
        S_LOW: begin
          if (cnt == LAST) begin
            cnt <= '0;
            st  <= S_HIGH;
            if (rd_q) begin
              if (idx) hst_rdata[15:8] <= nf_dq_i;
              else     hst_rdata[7:0]  <= nf_dq_i;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HIGH: begin
          if (cnt == LAST) begin
            cnt <= '0;
            if (wide_q && !idx) begin
              idx <= 1'b1;
              st  <= S_LOW;
            end else begin
              st      <= S_IDLE;
              hst_ack <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign nf_cle   = mode_q[0];
  assign nf_ale   = mode_q[1];
  assign card_pwr = mode_q[2];
  assign act_led  = mode_q[3];
  assign nf_ce_n  = !mode_q[4];
  assign nf_wp_n  = mode_q[7];
  assign nf_we_n  = !(st == S_LOW && !rd_q);
  assign nf_re_n  = !(st == S_LOW && rd_q);
  assign nf_dq_oe = (st != S_IDLE) && !rd_q;
  assign nf_dq_o  = idx ? wbuf[15:8] : wbuf[7:0];

  assert_no_dual_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));

  assert_data_held_at_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_we_n) |-> $stable(nf_dq_o) && nf_dq_oe);

  assert_drive_while_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_we_n |-> nf_dq_oe);

  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hst_ack |=> !hst_ack);

  assert_reg_ack_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && hst_req && !hst_ack && hst_addr != A_DATA) |=> hst_ack);

  assert_ctrl_stable_in_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable({nf_cle, nf_ale, nf_ce_n, nf_wp_n}));

endmodule

// File: tb/nand_mode_bridge_tb.sv
module nand_mode_bridge_tb_top;
  localparam int PH = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hst_req = 0, hst_wr = 0, hst_wide = 0;
  logic [1:0] hst_addr = 0;
  logic [15:0] hst_wdata = 0;
  logic [15:0] hst_rdata;
  logic hst_ack, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_wp_n, nf_dq_oe;
  logic [7:0] nf_dq_o, nf_dq_i;
  logic nf_rb_n = 1'b1;
  logic card_pwr, act_led;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  nand_mode_bridge #(.PHASE_CLKS(PH)) dut_i (
    .clk, .rst_n, .hst_req, .hst_wr, .hst_wide, .hst_addr, .hst_wdata,
    .hst_rdata, .hst_ack, .nf_ce_n, .nf_cle, .nf_ale, .nf_we_n, .nf_re_n,
    .nf_wp_n, .nf_dq_o, .nf_dq_oe, .nf_dq_i, .nf_rb_n, .card_pwr, .act_led);

  function automatic logic [7:0] pat(input int c);
    return 8'(8'h3C + c * 29);
  endfunction

  // flash model and strobe monitor
  int rd_cnt = 0, mon_n = 0, we_low = 0, re_low = 0, stab_err = 0;
  logic [7:0] we_dq;
  logic [7:0] mon_b [0:1023];
  logic       mon_cle [0:1023];
  logic       mon_ale [0:1023];
  logic       mon_ce [0:1023];
  int         mon_len [0:1023];

  assign nf_dq_i = pat(rd_cnt);

  always @(negedge clk) begin
    if (!nf_we_n) begin
      if (we_low == 0) we_dq = nf_dq_o;
      else if (nf_dq_o !== we_dq || !nf_dq_oe) stab_err++;
      we_low++;
    end else if (we_low != 0) begin
      if (nf_dq_o !== we_dq) stab_err++;
      mon_b[mon_n] = we_dq; mon_cle[mon_n] = nf_cle; mon_ale[mon_n] = nf_ale;
      mon_ce[mon_n] = !nf_ce_n; mon_len[mon_n] = we_low;
      mon_n++; we_low = 0;
    end
    if (!nf_re_n) begin
      re_low++;
    end else if (re_low != 0) begin
      mon_b[mon_n] = pat(rd_cnt); mon_cle[mon_n] = nf_cle; mon_ale[mon_n] = nf_ale;
      mon_ce[mon_n] = !nf_ce_n; mon_len[mon_n] = re_low;
      mon_n++; re_low = 0; rd_cnt++;
    end
    if (!nf_we_n && !nf_re_n) stab_err++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host(input logic wr, input logic wide, input logic [1:0] addr,
                      input logic [15:0] wd, output logic [15:0] rd, output int lat);
    @(negedge clk);
    hst_req = 1; hst_wr = wr; hst_wide = wide; hst_addr = addr; hst_wdata = wd;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!hst_ack && lat < 1000);
    rd = hst_rdata;
    hst_req = 0;
  endtask

  task automatic set_mode(input logic [7:0] m);
    logic [15:0] r; int lat;
    host(1, 0, 2'd1, {8'hA5, m}, r, lat);
    chk(lat == 1, "R8 mode write latency", lat, 1);
  endtask

  task automatic data_access(input logic [7:0] m, input logic wr, input logic wide,
                             input logic [15:0] wd);
    logic [15:0] r; int lat, base, se, nb, c0;
    logic [7:0] b [0:1];
    logic [15:0] exp_r;
    base = mon_n; se = stab_err; c0 = rd_cnt;
    nb = wide ? 2 : 1;
    host(wr, wide, 2'd0, wd, r, lat);
    chk(lat == (wide ? 4*PH+1 : 2*PH+1), "R8 data latency", lat, wide ? 4*PH+1 : 2*PH+1);
    chk(mon_n - base == nb, wide ? "R4/R7 strobe count" : "R5 strobe count", mon_n - base, nb);
    chk(stab_err == se, "R6 data hold / R11 strobes", stab_err - se, 0);
    if (wr) begin
      b[0] = wd[7:0]; b[1] = wd[15:8];
    end else begin
      b[0] = pat(c0); b[1] = pat(c0 + 1);
    end
    for (int i = 0; i < nb; i++) begin
      chk(mon_b[base+i] == b[i], wr ? "R4 write byte order" : "R7 read byte order", mon_b[base+i], b[i]);
      chk(mon_len[base+i] == PH, "R4 strobe low length", mon_len[base+i], PH);
      chk({mon_cle[base+i], mon_ale[base+i], mon_ce[base+i]} == {m[0], m[1], m[4]},
          "R10 control during cycle", {mon_cle[base+i], mon_ale[base+i], mon_ce[base+i]},
          {m[0], m[1], m[4]});
    end
    if (!wr) begin
      exp_r = wide ? {b[1], b[0]} : {8'h00, b[0]};
      chk(r == exp_r, "R7 read data", r, exp_r);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] r; int lat;
    logic [7:0] modes [0:2];
    logic [15:0] pats [0:3];
    modes[0] = 8'h94; modes[1] = 8'h95; modes[2] = 8'h96;
    pats[0] = 16'h1234; pats[1] = 16'hFF00; pats[2] = 16'h00FF; pats[3] = 16'hA55A;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk({nf_ce_n, nf_we_n, nf_re_n} == 3'b111, "R1 strobes idle", {nf_ce_n, nf_we_n, nf_re_n}, 7);
    chk({nf_cle, nf_ale, nf_wp_n, card_pwr, act_led, hst_ack} == 6'b0, "R1 controls low",
        {nf_cle, nf_ale, nf_wp_n, card_pwr, act_led, hst_ack}, 0);
    rst_n = 1;
    host(0, 0, 2'd1, 16'h0, r, lat);
    chk(r == 16'h0000, "R1 mode after reset", r, 0);

    // R2 exhaustive mode sweep
    for (int m = 0; m < 256; m++) begin
      set_mode(8'(m));
      @(negedge clk);
      chk({nf_cle, nf_ale, card_pwr, act_led, nf_ce_n, nf_wp_n} ==
          {m[0], m[1], m[2], m[3], !m[4], m[7]}, "R2 pin map",
          {nf_cle, nf_ale, card_pwr, act_led, nf_ce_n, nf_wp_n},
          {m[0], m[1], m[2], m[3], !m[4], m[7]});
      host(0, 0, 2'd1, 16'h0, r, lat);
      chk(r == 16'(m), "R2 mode readback", r, m);
    end

    // R3 named mode values
    set_mode(8'h94); @(negedge clk);
    chk({nf_ce_n, nf_cle, nf_ale} == 3'b000, "R3 data mode", {nf_ce_n, nf_cle, nf_ale}, 0);
    set_mode(8'h95); @(negedge clk);
    chk({nf_ce_n, nf_cle, nf_ale} == 3'b010, "R3 command mode", {nf_ce_n, nf_cle, nf_ale}, 2);
    set_mode(8'h96); @(negedge clk);
    chk({nf_ce_n, nf_cle, nf_ale} == 3'b001, "R3 address mode", {nf_ce_n, nf_cle, nf_ale}, 1);
    set_mode(8'h00); @(negedge clk);
    chk({nf_ce_n, nf_cle, nf_ale} == 3'b100, "R3 standby", {nf_ce_n, nf_cle, nf_ale}, 4);
    set_mode(8'h0C); @(negedge clk);
    chk(card_pwr == 1'b1, "R3 power on", card_pwr, 1);
    set_mode(8'h08); @(negedge clk);
    chk(card_pwr == 1'b0, "R3 power off", card_pwr, 0);

    // R4 R5 R7 data sweep over modes, widths, directions, patterns
    for (int mi = 0; mi < 3; mi++) begin
      set_mode(modes[mi]);
      for (int p = 0; p < 4; p++) begin
        data_access(modes[mi], 1, 1, pats[p]);
        data_access(modes[mi], 1, 0, pats[p]);
        data_access(modes[mi], 0, 1, pats[p]);
        data_access(modes[mi], 0, 0, pats[p]);
      end
    end

    // R5 command reset opcode, R10 mode change applies to next cycle
    set_mode(8'h95);
    data_access(8'h95, 1, 0, 16'h00FF);
    set_mode(8'h96);
    data_access(8'h96, 1, 0, 16'h0000);
    set_mode(8'h94);
    data_access(8'h94, 1, 1, 16'hBEEF);

    // R9 status busy bit
    for (int b = 0; b < 2; b++) begin
      nf_rb_n = b[0];
      repeat (3) @(negedge clk);
      host(0, 0, 2'd2, 16'h0, r, lat);
      chk(r == {8'h00, !b[0], 7'h00}, "R9 status busy", r, {8'h00, !b[0], 7'h00});
      chk(lat == 1, "R8 status latency", lat, 1);
    end
    nf_rb_n = 1;

    repeat (4) @(negedge clk);
    chk(stab_err == 0, "R11 no overlapping strobes", stab_err, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule